// File: doc/BRIEF.md
# DMA Channel Completion and Linking Control

This block keeps the control and status flags of one DMA channel that decide what happens when the channel's major loop runs out. It tracks whether the channel is busy and whether it has finished. When the major iteration count reaches zero it can do three things: send a start request to a chosen channel, strobe the channel's hardware request enable to clear it, and ask for the channel's next descriptor to be reloaded.

A CPU port writes one 16-bit control word and a separate next-descriptor pointer. The DMA engine reports four events: service start, minor-loop completion, major count at zero, and error. All responses are registered. They appear in the cycle after the event, which is also the first cycle in which the done flag reads as set.

The link enable and the descriptor-chaining enable are coherency-protected. If software writes either of them while the done flag is set, the bit stores zero. A descriptor pointer that is not aligned to the 32-byte descriptor size raises a configuration error pulse and no reload request.

Top module: `dma_chan_finish_ctl`

## Requirements
- R1: After reset, every flag in the control word reads zero, the stored pointer is zero, and all request and strobe outputs are low.
- R2: The control word has these fields: link target channel in bits 11:8, done in bit 7, active in bit 6, link enable in bit 5, chaining enable in bit 4, request-disable in bit 3. Bits 15:12 and 2:0 read as zero, and writing them has no effect.
- R3: A write while done reads as set stores zero in link enable (bit 5) and chaining enable (bit 4). The other writable fields are stored normally.
- R4: A major-count-zero event sets done, which reads as set from the next cycle. Done is cleared by a write with bit 7 at one, or by a service-start event. If a clear and the set fall in the same cycle, done ends up set.
- R5: A service-start event sets active. A minor-loop-complete event or an error event clears it. If a clear and a start fall in the same cycle, active ends up clear.
- R6: On a major-count-zero event with link enable set, `link_start_o` carries a single-cycle one-hot pulse on the bit selected by the link target field, in the cycle done first reads as set. With link enable clear, `link_start_o` stays zero.
- R7: On a major-count-zero event with request-disable set, `req_en_clr_o` pulses for one cycle at the same time. Otherwise it stays low.
- R8: On a major-count-zero event with chaining enable set and a stored pointer whose low 5 bits are zero, `reload_req_o` pulses for one cycle and `reload_ptr_o` shows the pointer from then until the next reload.
- R9: On a major-count-zero event with chaining enable set and a pointer whose low 5 bits are not all zero, `cfg_err_o` pulses for one cycle, `reload_req_o` stays low and `reload_ptr_o` keeps its value.
- R10: A pointer write takes effect for events in later cycles. An event in the same cycle as a control or pointer write acts on the values held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 16 | Control word write value |
| cfg_rd_data | output | 16 | Current control word |
| ptr_wr_en | input | 1 | Next-descriptor pointer write strobe |
| ptr_wr_data | input | PTR_W | Next-descriptor pointer value |
| evt_svc_start | input | 1 | Engine begins servicing the channel |
| evt_minor_done | input | 1 | Minor loop completed |
| evt_major_zero | input | 1 | Major iteration count reached zero |
| evt_error | input | 1 | Engine detected an error |
| link_start_o | output | NUM_CH | One-hot start request to the linked channel |
| req_en_clr_o | output | 1 | Clear strobe for the channel's request enable |
| reload_req_o | output | 1 | Descriptor reload request |
| reload_ptr_o | output | PTR_W | Address of the descriptor to reload |
| cfg_err_o | output | 1 | Misaligned chaining pointer at completion |

## Verification
Several functions can act in the same cycle. The bench drives a software write of the done bit together with a major-count-zero event. It also drives a control write that tries to set the link enables in the same cycle that done becomes set, and a service start together with a minor-loop completion. A behavioural model resolves each collision by the priorities stated in R3, R4, R5 and R10. Every clock it compares the control word and all outputs against the model, so a wrong winner shows up in the cycle it occurs.

// File: rtl/dma_fin_pkg.sv
package dma_fin_pkg;

  localparam int WORD_W   = 16;
  localparam int LINK_LSB = 8;
  localparam int LINK_W   = 4;
  localparam int DONE_BIT = 7;
  localparam int ACT_BIT  = 6;
  localparam int LEN_BIT  = 5;
  localparam int SGEN_BIT = 4;
  localparam int DREQ_BIT = 3;

  typedef struct packed {
    logic [LINK_W-1:0] link_ch;
    logic              link_en;
    logic              sg_en;
    logic              dreq;
  } cfg_t;

  function automatic logic [WORD_W-1:0] pack_word(input cfg_t c, input logic done,
                                                  input logic act);
    logic [WORD_W-1:0] w;
    w = '0;
    w[LINK_LSB +: LINK_W] = c.link_ch;
    w[DONE_BIT] = done;
    w[ACT_BIT]  = act;
    w[LEN_BIT]  = c.link_en;
    w[SGEN_BIT] = c.sg_en;
    w[DREQ_BIT] = c.dreq;
    return w;
  endfunction

  function automatic logic ptr_is_aligned(input logic [63:0] p, input int align_w);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 64; i++)
      if (i < align_w && p[i]) ok = 1'b0;
    return ok;
  endfunction

endpackage

// File: rtl/dma_fin_cfg.sv
module dma_fin_cfg
  import dma_fin_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LINK_W-1:0] wr_link_ch,
  input  logic             wr_link_en,
  input  logic             wr_sg_en,
  input  logic             wr_dreq,
  input  logic             done_q,
  input  logic             ptr_wr_en,
  input  logic [PTR_W-1:0] ptr_wr_data,
  output cfg_t             cfg_q,
  output logic [PTR_W-1:0] ptr_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      ptr_q <= '0;
    end else begin
      if (wr_en) begin
        cfg_q.link_ch <= wr_link_ch;
        cfg_q.dreq    <= wr_dreq;
        cfg_q.link_en <= wr_link_en & ~done_q;
        cfg_q.sg_en   <= wr_sg_en & ~done_q;
      end
      if (ptr_wr_en) ptr_q <= ptr_wr_data;
    end
  end

endmodule

// File: rtl/dma_fin_status.sv
module dma_fin_status (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_done_clr,
  input  logic svc_start,
  input  logic minor_done,
  input  logic major_zero,
  input  logic error,
  output logic done_q,
  output logic active_q
);

  logic done_d, active_d;

  always_comb begin
    done_d = done_q;
    if (major_zero)                   done_d = 1'b1;
    else if (svc_start | sw_done_clr) done_d = 1'b0;
    active_d = active_q;
    if (minor_done | error)  active_d = 1'b0;
    else if (svc_start)      active_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      active_q <= 1'b0;
    end else begin
      done_q   <= done_d;
      active_q <= active_d;
    end
  end

endmodule

// File: rtl/dma_fin_dispatch.sv
module dma_fin_dispatch
  import dma_fin_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int PTR_W   = 32,
  parameter int ALIGN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              major_zero,
  input  cfg_t              cfg,
  input  logic [PTR_W-1:0]  ptr,
  output logic [NUM_CH-1:0] link_start_q,
  output logic              clr_q,
  output logic              reload_q,
  output logic              cfg_err_q,
  output logic [PTR_W-1:0]  rptr_q
);

  logic [NUM_CH-1:0] link_hit;
  logic              ptr_ok;
  logic              sg_fire;
  logic              sg_bad;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
    assign link_hit[i] = cfg.link_en && (32'(cfg.link_ch) == i);
  end

  assign ptr_ok  = ptr_is_aligned(64'(ptr), ALIGN_W);
  assign sg_fire = major_zero & cfg.sg_en & ptr_ok;
  assign sg_bad  = major_zero & cfg.sg_en & ~ptr_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_start_q <= '0;
      clr_q        <= 1'b0;
      reload_q     <= 1'b0;
      cfg_err_q    <= 1'b0;
      rptr_q       <= '0;
    end else begin
      link_start_q <= major_zero ? link_hit : '0;
      clr_q        <= major_zero & cfg.dreq;
      reload_q     <= sg_fire;
      cfg_err_q    <= sg_bad;
      if (sg_fire) rptr_q <= ptr;
    end
  end

endmodule

// File: rtl/dma_chan_finish_ctl.sv
module dma_chan_finish_ctl
  import dma_fin_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int PTR_W      = 32,
  parameter int DESC_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [15:0]       cfg_wr_data,
  output logic [15:0]       cfg_rd_data,
  input  logic              ptr_wr_en,
  input  logic [PTR_W-1:0]  ptr_wr_data,
  input  logic              evt_svc_start,
  input  logic              evt_minor_done,
  input  logic              evt_major_zero,
  input  logic              evt_error,
  output logic [NUM_CH-1:0] link_start_o,
  output logic              req_en_clr_o,
  output logic              reload_req_o,
  output logic [PTR_W-1:0]  reload_ptr_o,
  output logic              cfg_err_o
);

  localparam int ALIGN_W = $clog2(DESC_BYTES);

  cfg_t             cfg_q;
  logic [PTR_W-1:0] ptr_q;
  logic             done_q, active_q;
  logic             sw_done_clr;
  logic             unused_wr_bits;

  assign sw_done_clr    = cfg_wr_en & cfg_wr_data[DONE_BIT];
  assign unused_wr_bits = ^{cfg_wr_data[15:12], cfg_wr_data[ACT_BIT], cfg_wr_data[2:0]};

  dma_fin_cfg #(.PTR_W(PTR_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr_en),
    .wr_link_ch (cfg_wr_data[LINK_LSB +: LINK_W]),
    .wr_link_en (cfg_wr_data[LEN_BIT]),
    .wr_sg_en   (cfg_wr_data[SGEN_BIT]),
    .wr_dreq    (cfg_wr_data[DREQ_BIT]),
    .done_q     (done_q),
    .ptr_wr_en  (ptr_wr_en),
    .ptr_wr_data(ptr_wr_data),
    .cfg_q      (cfg_q),
    .ptr_q      (ptr_q)
  );

  dma_fin_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_done_clr(sw_done_clr),
    .svc_start  (evt_svc_start),
    .minor_done (evt_minor_done),
    .major_zero (evt_major_zero),
    .error      (evt_error),
    .done_q     (done_q),
    .active_q   (active_q)
  );

  dma_fin_dispatch #(.NUM_CH(NUM_CH), .PTR_W(PTR_W), .ALIGN_W(ALIGN_W)) u_disp (
    .clk         (clk),
    .rst_n       (rst_n),
    .major_zero  (evt_major_zero),
    .cfg         (cfg_q),
    .ptr         (ptr_q),
    .link_start_q(link_start_o),
    .clr_q       (req_en_clr_o),
    .reload_q    (reload_req_o),
    .cfg_err_q   (cfg_err_o),
    .rptr_q      (reload_ptr_o)
  );

  assign cfg_rd_data = pack_word(cfg_q, done_q, active_q);

endmodule

// File: rtl/dma_fin_chk.sv
module dma_fin_chk #(
  parameter int NUM_CH  = 16,
  parameter int PTR_W   = 32,
  parameter int ALIGN_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [15:0]       cfg_rd_data,
  input logic              evt_minor_done,
  input logic              evt_major_zero,
  input logic              evt_error,
  input logic [NUM_CH-1:0] link_start_o,
  input logic              req_en_clr_o,
  input logic              reload_req_o,
  input logic [PTR_W-1:0]  reload_ptr_o,
  input logic              cfg_err_o
);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[15:12] == 4'd0 && cfg_rd_data[2:0] == 3'd0); // R2
  AST_LOCKED_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_rd_data[7]) |=> (!cfg_rd_data[5] && !cfg_rd_data[4])); // R3
  AST_DONE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_major_zero |=> cfg_rd_data[7]); // R4
  AST_ACTIVE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_minor_done || evt_error) |=> !cfg_rd_data[6]); // R5
  AST_LINK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(link_start_o)); // R6
  AST_LINK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|link_start_o) |-> (cfg_rd_data[7] && $past(evt_major_zero))); // R6
  AST_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_en_clr_o |-> $past(evt_major_zero)); // R7
  AST_RELOAD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    reload_req_o |-> (reload_ptr_o[ALIGN_W-1:0] == '0)); // R8
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reload_req_o && cfg_err_o)); // R9
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> $stable(reload_ptr_o)); // R9

endmodule

bind dma_chan_finish_ctl dma_fin_chk #(
  .NUM_CH(NUM_CH), .PTR_W(PTR_W), .ALIGN_W(ALIGN_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_wr_en     (cfg_wr_en),
  .cfg_rd_data   (cfg_rd_data),
  .evt_minor_done(evt_minor_done),
  .evt_major_zero(evt_major_zero),
  .evt_error     (evt_error),
  .link_start_o  (link_start_o),
  .req_en_clr_o  (req_en_clr_o),
  .reload_req_o  (reload_req_o),
  .reload_ptr_o  (reload_ptr_o),
  .cfg_err_o     (cfg_err_o)
);

// File: tb/tb_dma_chan_finish_ctl.sv
`timescale 1ns/1ps
module tb_dma_chan_finish_ctl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 0, se = 0, st = 0, mn = 0, mz = 0, er = 0;
  logic [15:0] wd = '0;
  logic [31:0] sd = '0;
  logic [15:0] rd;
  logic [15:0] ls;
  logic        clr, rl, ce;
  logic [31:0] rptr;

  int vectors = 0, fails = 0;
  bit running = 0;

  // behavioural reference state
  int m_ch, m_done, m_act, m_len, m_sgen, m_dreq;
  logic [31:0] m_ptr, m_rptr;
  int o_ls_idx, o_clr, o_rl, o_ce;

  always #5 clk = ~clk;

  dma_chan_finish_ctl dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(we), .cfg_wr_data(wd), .cfg_rd_data(rd),
    .ptr_wr_en(se), .ptr_wr_data(sd),
    .evt_svc_start(st), .evt_minor_done(mn), .evt_major_zero(mz), .evt_error(er),
    .link_start_o(ls), .req_en_clr_o(clr), .reload_req_o(rl),
    .reload_ptr_o(rptr), .cfg_err_o(ce)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [15:0] ew, el;
    ew = 16'((m_ch << 8) | (m_done << 7) | (m_act << 6) | (m_len << 5) | (m_sgen << 4) | (m_dreq << 3));
    el = (o_ls_idx >= 0) ? 16'(1 << o_ls_idx) : 16'd0;
    chk("R2/R3/R4/R5 control word", 32'(rd), 32'(ew));
    chk("R6 link start", 32'(ls), 32'(el));
    chk("R7 request-enable clear", 32'(clr), 32'(o_clr));
    chk("R8 reload request", 32'(rl), 32'(o_rl));
    chk("R8 reload pointer", rptr, m_rptr);
    chk("R9 config error", 32'(ce), 32'(o_ce));
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ch = 0; m_done = 0; m_act = 0; m_len = 0; m_sgen = 0; m_dreq = 0;
      m_ptr = 0; m_rptr = 0; o_ls_idx = -1; o_clr = 0; o_rl = 0; o_ce = 0;
    end else begin
      int pd;
      pd = m_done;
      o_ls_idx = -1; o_clr = 0; o_rl = 0; o_ce = 0;
      if (mz) begin                       // R10: act on pre-write values
        if (m_len != 0) o_ls_idx = m_ch;
        o_clr = m_dreq;
        if (m_sgen != 0) begin
          if (m_ptr % 32 == 0) begin o_rl = 1; m_rptr = m_ptr; end
          else o_ce = 1;
        end
      end
      if (mz) m_done = 1;
      else if (st || (we && wd[7])) m_done = 0;
      if (mn || er) m_act = 0;
      else if (st) m_act = 1;
      if (we) begin
        m_ch   = int'(wd[11:8]);
        m_dreq = int'(wd[3]);
        m_len  = (pd != 0) ? 0 : int'(wd[5]);
        m_sgen = (pd != 0) ? 0 : int'(wd[4]);
      end
      if (se) m_ptr = sd;
    end
    #2;
    if (running) compare_all();
  end

  task automatic cyc(input logic w, input logic [15:0] wdat, input logic s,
                     input logic [31:0] sdat, input logic a, input logic b,
                     input logic c, input logic d);
    @(negedge clk);
    we = w; wd = wdat; se = s; sd = sdat; st = a; mn = b; mz = c; er = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 word after reset", 32'(rd), 0);
    chk("R1 outputs after reset", {ls, 13'd0, clr, rl, ce}, 0);
    chk("R1 pointer after reset", rptr, 0);
    running = 1;
    // R2: reserved bits written high have no effect
    cyc(1, 16'hF0C7, 0, 0, 0, 0, 0, 0);
    // R5: start then minor, then start+minor collide
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 1, 1, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    // R6/R7: link to channel 9 with request-disable
    cyc(1, 16'h0928, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    idle(2);
    // R3: enables written while done is set store zero
    cyc(1, 16'h0338, 0, 0, 0, 0, 0, 0);
    // R4: software clear and hardware set in the same cycle
    cyc(1, 16'h0080, 0, 0, 0, 0, 1, 0);
    cyc(1, 16'h0080, 0, 0, 0, 0, 0, 0);
    // R6: link disabled -> no start
    cyc(1, 16'h0500, 0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, 0);                  // R4 start clears done
    // R8: aligned pointer reload; R10 pointer write same cycle as event
    cyc(1, 16'h0010, 1, 32'h0000_1240, 0, 0, 0, 0);
    cyc(0, 0, 1, 32'h0000_2000, 0, 0, 1, 0);
    cyc(1, 16'h0080, 0, 0, 0, 0, 0, 0);
    cyc(1, 16'h0010, 0, 0, 0, 0, 1, 0);
    // R9: misaligned pointer
    cyc(1, 16'h0080, 1, 32'h0000_3004, 0, 0, 0, 0);
    cyc(1, 16'h0010, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    idle(2);
    // mixed pseudo-random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0] & r[1], 16'($urandom), r[2] & r[3] & r[4],
          (r[5] ? 32'($urandom) & 32'hFFFF_FFE0 : 32'($urandom)),
          r[6] & r[7], r[8] & r[9], r[10] & r[11] & r[12], r[13] & r[14] & r[15]);
    end
    idle(3);
    report();
  end

endmodule